// File: doc/BRIEF.md
# Cascaded Dual Interrupt Controller

This block joins two eight-input priority interrupt controllers. The secondary controller's request output feeds input 2 of the primary controller, which leaves fifteen request lines that software can use. The block keeps a request, in-service and mask register for each controller. It resolves fully nested priority and drives one interrupt line toward the processor. When the processor acknowledges, the block returns an eight-bit vector.

Software reaches the block through a write-only byte I/O port. Each controller has an even and an odd address. A write to the even address with data bit 4 set begins initialization. Later writes to the odd address then supply the vector base, the cascade word and the mode word. Once initialization is done, a write to the odd address loads the mask. A write to the even address with bits 4 and 3 clear is an end-of-interrupt command. Two extra registers, one for each controller, choose edge or level triggering line by line. Lines that a parameter marks as active-low are inverted at the boundary, so inside the block a high level always means a request.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After reset, every mask bit is 0, every line is edge-triggered and both vector bases are 0. A rising edge on line 1 raises `int_o`, and the acknowledge then returns vector 01h.
- R2: A write at 20h/A0h with data bit 4 set starts initialization. The next odd-address writes are taken in this order: the vector base (data bits 7:3); the cascade word, skipped when bit 1 of the start word is set; and the mode word, taken only when bit 0 of the start word is set. After that, odd-address writes load the mask. A start word also clears the mask, in-service and request state.
- R3: Lower line numbers win inside a controller. Lines 8–15 belong to the secondary controller and all rank at the position of primary line 2, so the order is 0, 1, 8…15, 3…7. A primary line n gives vector {primary base, n}. A line 8+k gives vector {secondary base, k}.
- R4: Setting mask bit n (odd address, after initialization) stops the pending line n from raising `int_o`. Clearing the bit later presents the held request.
- R5: A pending request raises `int_o` only if it outranks every in-service bit of its controller.
- R6: Writing 20h to the even address clears the highest-priority in-service bit. Writing 60h|L clears in-service bit L. Clearing a bit that is not set changes nothing.
- R7: In edge mode a request is latched on a rising input, stays latched after the input falls, and is cleared by its acknowledge. An input held high does not request again.
- R8: Setting a bit in the control register at 4D0h (lines 0–7) or 4D1h (lines 8–15) makes that line level-triggered. Its request follows the input and disappears if the input falls before the acknowledge.
- R9: Lines 0, 2 and 8 stay edge-triggered whatever value the control registers hold. Raw input 2 has no effect, because primary input 2 carries the cascade.
- R10: A line whose bit is set in parameter `ACTIVE_LOW` requests when its pin is low.
- R11: An acknowledge while `int_o` is low returns vector {primary base, 7} and changes no state.
- R12: `vec_vld_o` is high exactly in the cycle after the cycle in which `int_ack_i` is high. `vec_o` updates only then and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_wr_en | input | 1 | I/O write strobe |
| io_addr | input | 16 | I/O byte address |
| io_wdata | input | 8 | I/O write data |
| irq_raw | input | 16 | Raw request pins, index = line number (bit 2 unused) |
| int_ack_i | input | 1 | One-cycle acknowledge from the processor |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector of the last acknowledge |
| vec_vld_o | output | 1 | Vector valid pulse |

## Verification
The bench builds the block with `ACTIVE_LOW` = 8000h, so line 15 is active-low. This lets an inverted secondary line be tested alongside normal lines and ranked against them. Random masks and bursts of pulses across both controllers check the cascaded priority order, the unmasking of held requests and the double end-of-interrupt. Directed cases cover nesting, level triggering, the forced edge lines and spurious acknowledges.

// File: rtl/dic_pkg.sv
package dic_pkg;
    localparam int PIC_LINES = 8;
    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int IDX_W     = $clog2(PIC_LINES);
    localparam int CAS_LINE  = 2;

    localparam logic [ADDR_W-1:0] PRI_EVEN = 16'h0020;
    localparam logic [ADDR_W-1:0] PRI_ODD  = 16'h0021;
    localparam logic [ADDR_W-1:0] SEC_EVEN = 16'h00A0;
    localparam logic [ADDR_W-1:0] SEC_ODD  = 16'h00A1;
    localparam logic [ADDR_W-1:0] TRIG_PRI = 16'h04D0;
    localparam logic [ADDR_W-1:0] TRIG_SEC = 16'h04D1;

    typedef enum logic [1:0] {
        STEP_IDLE,
        STEP_BASE,
        STEP_CASC,
        STEP_MODE
    } init_step_e;

    typedef struct packed {
        logic even;
        logic odd;
        logic trig;
    } wr_sel_t;
endpackage

// File: rtl/dic_addr_decode.sv
module dic_addr_decode
    import dic_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output wr_sel_t           pri_sel,
    output wr_sel_t           sec_sel
);
    always_comb begin
        pri_sel.even = wr_en && (addr == PRI_EVEN);
        pri_sel.odd  = wr_en && (addr == PRI_ODD);
        pri_sel.trig = wr_en && (addr == TRIG_PRI);
        sec_sel.even = wr_en && (addr == SEC_EVEN);
        sec_sel.odd  = wr_en && (addr == SEC_ODD);
        sec_sel.trig = wr_en && (addr == TRIG_SEC);
    end
endmodule

// File: rtl/dic_prio_find.sv
module dic_prio_find #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = i[IW-1:0];
            end
        end
    end
endmodule

// File: rtl/dic_core.sv
module dic_core
    import dic_pkg::*;
#(
    parameter int                 LINES       = PIC_LINES,
    parameter logic [LINES-1:0]   FORCE_EDGE  = '0,
    parameter bit                 HAS_CASCADE = 1'b0,
    parameter int                 CAS_IDX     = CAS_LINE,
    localparam int                IW          = $clog2(LINES),
    localparam int                BASE_W      = DATA_W - IW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_sel_t           sel,
    input  logic [DATA_W-1:0] data,
    input  logic [LINES-1:0]  req,
    input  logic              cas_req,
    input  logic              ack,
    output logic              int_o,
    output logic [IW-1:0]     win_idx,
    output logic [BASE_W-1:0] base_o
);
    typedef struct packed {
        logic [LINES-1:0]  irr;
        logic [LINES-1:0]  isr;
        logic [LINES-1:0]  imr;
        logic [LINES-1:0]  trig;
        logic [LINES-1:0]  prev;
        logic [BASE_W-1:0] base;
        init_step_e        step;
        logic              want_mode;
        logic              single;
    } core_st_t;

    core_st_t st_q, st_d;

    logic [LINES-1:0] level, rise, pend, cand;
    logic             cand_found, isr_found, int_raw;
    logic [IW-1:0]    cand_idx, isr_idx;

    always_comb begin
        level = st_q.trig & ~FORCE_EDGE;
        rise  = req & ~st_q.prev;
        pend  = st_q.irr;
        if (HAS_CASCADE) pend[CAS_IDX] = cas_req;
        cand  = pend & ~st_q.imr;
    end

    dic_prio_find #(.N(LINES)) u_cand (.vec(cand),     .found(cand_found), .idx(cand_idx));
    dic_prio_find #(.N(LINES)) u_isr  (.vec(st_q.isr), .found(isr_found),  .idx(isr_idx));

    assign int_raw = cand_found && (!isr_found || (cand_idx < isr_idx));

    always_comb begin
        st_d      = st_q;
        st_d.prev = req;
        st_d.irr  = ((st_q.irr | rise) & ~level) | (req & level);

        if (sel.trig) st_d.trig = data[LINES-1:0];

        if (sel.even) begin
            if (data[4]) begin
                st_d.step      = STEP_BASE;
                st_d.want_mode = data[0];
                st_d.single    = data[1];
                st_d.imr       = '0;
                st_d.isr       = '0;
                st_d.irr       = '0;
            end else if (!data[3]) begin
                case (data[7:5])
                    3'b001: if (isr_found) st_d.isr[isr_idx] = 1'b0;
                    3'b011: st_d.isr[data[IW-1:0]] = 1'b0;
                    default: ;
                endcase
            end
        end

        if (sel.odd) begin
            case (st_q.step)
                STEP_BASE: begin
                    st_d.base = data[DATA_W-1:IW];
                    if (!st_q.single)        st_d.step = STEP_CASC;
                    else if (st_q.want_mode) st_d.step = STEP_MODE;
                    else                     st_d.step = STEP_IDLE;
                end
                STEP_CASC: st_d.step = st_q.want_mode ? STEP_MODE : STEP_IDLE;
                STEP_MODE: st_d.step = STEP_IDLE;
                default:   st_d.imr  = data[LINES-1:0];
            endcase
        end

        if (ack && int_raw) begin
            st_d.isr[cand_idx] = 1'b1;
            if (!level[cand_idx]) st_d.irr[cand_idx] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{irr: '0, isr: '0, imr: '0, trig: '0, prev: '0,
                      base: '0, step: STEP_IDLE, want_mode: 1'b0, single: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign int_o   = int_raw;
    assign win_idx = cand_idx;
    assign base_o  = st_q.base;
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
    import dic_pkg::*;
#(
    parameter logic [2*PIC_LINES-1:0] ACTIVE_LOW = '0,
    localparam int NUM_LINES = 2 * PIC_LINES,
    localparam int BASE_W    = DATA_W - IDX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 io_wr_en,
    input  logic [ADDR_W-1:0]    io_addr,
    input  logic [DATA_W-1:0]    io_wdata,
    input  logic [NUM_LINES-1:0] irq_raw,
    input  logic                 int_ack_i,
    output logic                 int_o,
    output logic [DATA_W-1:0]    vec_o,
    output logic                 vec_vld_o
);
    localparam logic [IDX_W-1:0]     CAS_SEL   = IDX_W'(CAS_LINE);
    localparam logic [IDX_W-1:0]     SPUR_IDX  = IDX_W'(PIC_LINES - 1);
    localparam logic [PIC_LINES-1:0] PRI_EDGE  = PIC_LINES'(1) | (PIC_LINES'(1) << CAS_LINE);
    localparam logic [PIC_LINES-1:0] SEC_EDGE  = PIC_LINES'(1);

    typedef struct packed {
        logic [DATA_W-1:0] vec;
        logic              vld;
    } top_st_t;

    top_st_t top_q, top_d;

    wr_sel_t               pri_sel, sec_sel;
    logic [NUM_LINES-1:0]  req_norm;
    logic                  pri_int, sec_int, sec_ack;
    logic [IDX_W-1:0]      pri_idx, sec_idx;
    logic [BASE_W-1:0]     pri_base, sec_base;

    assign req_norm = irq_raw ^ ACTIVE_LOW;

    dic_addr_decode u_dec (
        .wr_en  (io_wr_en),
        .addr   (io_addr),
        .pri_sel(pri_sel),
        .sec_sel(sec_sel)
    );

    assign sec_ack = int_ack_i && pri_int && (pri_idx == CAS_SEL);

    dic_core #(.FORCE_EDGE(PRI_EDGE), .HAS_CASCADE(1'b1)) u_pri (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (pri_sel),
        .data   (io_wdata),
        .req    (req_norm[PIC_LINES-1:0]),
        .cas_req(sec_int),
        .ack    (int_ack_i),
        .int_o  (pri_int),
        .win_idx(pri_idx),
        .base_o (pri_base)
    );

    dic_core #(.FORCE_EDGE(SEC_EDGE), .HAS_CASCADE(1'b0)) u_sec (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (sec_sel),
        .data   (io_wdata),
        .req    (req_norm[NUM_LINES-1:PIC_LINES]),
        .cas_req(1'b0),
        .ack    (sec_ack),
        .int_o  (sec_int),
        .win_idx(sec_idx),
        .base_o (sec_base)
    );

    always_comb begin
        top_d     = top_q;
        top_d.vld = int_ack_i;
        if (int_ack_i) begin
            if (!pri_int)                top_d.vec = {pri_base, SPUR_IDX};
            else if (pri_idx == CAS_SEL) top_d.vec = {sec_base, sec_idx};
            else                         top_d.vec = {pri_base, pri_idx};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '{vec: '0, vld: 1'b0};
        else        top_q <= top_d;
    end

    assign int_o     = pri_int;
    assign vec_o     = top_q.vec;
    assign vec_vld_o = top_q.vld;
endmodule

// File: rtl/dic_checker.sv
module dic_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       int_o,
    input logic       int_ack_i,
    input logic [7:0] vec_o,
    input logic       vec_vld_o
);
    p_ack_gives_vld_r12: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack_i |=> vec_vld_o)
        else $error("vec_vld_o missing after acknowledge");

    p_vld_only_after_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !int_ack_i |=> !vec_vld_o)
        else $error("vec_vld_o without acknowledge");

    p_vec_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !int_ack_i |=> $stable(vec_o))
        else $error("vec_o changed without acknowledge");

    p_spurious_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack_i && !int_o) |=> (vec_o[2:0] == 3'd7))
        else $error("spurious acknowledge vector index is not 7");
endmodule

bind dual_irq_ctrl dic_checker u_dic_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .int_o    (int_o),
    .int_ack_i(int_ack_i),
    .vec_o    (vec_o),
    .vec_vld_o(vec_vld_o)
);

// File: tb/test_dual_irq_ctrl.sv
module test_dual_irq_ctrl;
    localparam logic [15:0] ACT_LOW = 16'h8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr_en = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [15:0] act = '0;
    logic [15:0] irq_raw;
    logic        int_ack_i = 1'b0;
    logic        int_o;
    logic [7:0]  vec_o;
    logic        vec_vld_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    assign irq_raw = act ^ ACT_LOW;

    always #5 clk = ~clk;

    dual_irq_ctrl #(.ACTIVE_LOW(ACT_LOW)) i_dual_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .io_wr_en(io_wr_en), .io_addr(io_addr),
        .io_wdata(io_wdata), .irq_raw(irq_raw), .int_ack_i(int_ack_i),
        .int_o(int_o), .vec_o(vec_o), .vec_vld_o(vec_vld_o)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr_en = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] lines);
        @(negedge clk); act = act | lines;
        @(negedge clk); act = act & ~lines;
    endtask

    task automatic do_ack();
        @(negedge clk); int_ack_i = 1'b1;
        @(negedge clk); int_ack_i = 1'b0;
    endtask

    function automatic logic [7:0] exp_vec(input int line);
        return (line < 8) ? (8'h20 | 8'(line)) : (8'h28 | 8'(line - 8));
    endfunction

    function automatic int first_line(input logic [15:0] pend);
        for (int i = 0; i < 2; i++) if (pend[i]) return i;
        for (int i = 8; i < 16; i++) if (pend[i]) return i;
        for (int i = 3; i < 8; i++) if (pend[i]) return i;
        return -1;
    endfunction

    task automatic eoi(input int line);
        if (line >= 8) io_wr(16'h00A0, 8'h20);
        io_wr(16'h0020, 8'h20);
    endtask

    task automatic ack_expect(input string req, input int line);
        check(req, {7'd0, int_o}, 8'd1);
        do_ack();
        check(req, {7'd0, vec_vld_o}, 8'd1);
        check(req, vec_o, exp_vec(line));
    endtask

    task automatic drain(input string req, input logic [15:0] pend_in);
        logic [15:0] pend;
        pend = pend_in;
        while (pend != 0) begin
            int ln;
            ln = first_line(pend);
            ack_expect(req, ln);
            pend[ln] = 1'b0;
            eoi(ln);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", {7'd0, int_o}, 8'd0);
        check("R1", {7'd0, vec_vld_o}, 8'd0);
        pulse(16'h0002);
        check("R1", {7'd0, int_o}, 8'd1);
        do_ack();
        check("R1", vec_o, 8'h01);
        io_wr(16'h0020, 8'h20);

        // R2 single-controller sequence skips the cascade word
        io_wr(16'h0020, 8'h13); io_wr(16'h0021, 8'h40); io_wr(16'h0021, 8'h01);
        io_wr(16'h0021, 8'h08);
        pulse(16'h0008);
        check("R2", {7'd0, int_o}, 8'd0);
        pulse(16'h0010);
        do_ack();
        check("R2", vec_o, 8'h44);
        io_wr(16'h0020, 8'h20);

        // Full initialization of both controllers
        io_wr(16'h0020, 8'h11); io_wr(16'h0021, 8'h20); io_wr(16'h0021, 8'h04); io_wr(16'h0021, 8'h01);
        io_wr(16'h00A0, 8'h11); io_wr(16'h00A1, 8'h28); io_wr(16'h00A1, 8'h02); io_wr(16'h00A1, 8'h01);
        check("R2", {7'd0, int_o}, 8'd0);
        pulse(16'h0008);
        ack_expect("R2", 3); eoi(3);

        // R12 valid is a single pulse, vector held
        @(negedge clk);
        check("R12", {7'd0, vec_vld_o}, 8'd0);
        check("R12", vec_o, 8'h23);

        // R4 mask then unmask
        io_wr(16'h0021, 8'h20);
        pulse(16'h0020);
        check("R4", {7'd0, int_o}, 8'd0);
        io_wr(16'h0021, 8'h00);
        ack_expect("R4", 5); eoi(5);

        // R3 cascaded priority
        pulse(16'h0212);
        drain("R3", 16'h0212);
        check("R3", {7'd0, int_o}, 8'd0);

        // R5 nesting
        pulse(16'h0010);
        ack_expect("R5", 4);
        pulse(16'h0040);
        check("R5", {7'd0, int_o}, 8'd0);
        pulse(16'h0008);
        ack_expect("R5", 3);
        io_wr(16'h0020, 8'h20);
        check("R5", {7'd0, int_o}, 8'd0);
        io_wr(16'h0020, 8'h20);
        ack_expect("R5", 6); eoi(6);

        // R6 specific end-of-interrupt
        pulse(16'h0020);
        ack_expect("R6", 5);
        pulse(16'h0040);
        io_wr(16'h0020, 8'h66);
        check("R6", {7'd0, int_o}, 8'd0);
        io_wr(16'h0020, 8'h65);
        ack_expect("R6", 6); eoi(6);

        // R7 edge: held high does not retrigger
        @(negedge clk); act[3] = 1'b1;
        @(negedge clk);
        ack_expect("R7", 3); eoi(3);
        check("R7", {7'd0, int_o}, 8'd0);
        @(negedge clk); act[3] = 1'b0;
        pulse(16'h0008);
        ack_expect("R7", 3); eoi(3);

        // R8 level mode
        io_wr(16'h04D0, 8'h08);
        @(negedge clk); act[3] = 1'b1;
        @(negedge clk);
        check("R8", {7'd0, int_o}, 8'd1);
        act[3] = 1'b0;
        @(negedge clk);
        check("R8", {7'd0, int_o}, 8'd0);
        act[3] = 1'b1;
        @(negedge clk);
        ack_expect("R8", 3); eoi(3);
        check("R8", {7'd0, int_o}, 8'd1);
        act[3] = 1'b0;
        @(negedge clk);
        check("R8", {7'd0, int_o}, 8'd0);
        io_wr(16'h04D0, 8'h00);

        // R9 forced edge lines and dead input 2
        io_wr(16'h04D0, 8'h05); io_wr(16'h04D1, 8'h01);
        pulse(16'h0001);
        ack_expect("R9", 0); eoi(0);
        pulse(16'h0100);
        ack_expect("R9", 8); eoi(8);
        pulse(16'h0004);
        check("R9", {7'd0, int_o}, 8'd0);
        io_wr(16'h04D0, 8'h00); io_wr(16'h04D1, 8'h00);

        // R10 active-low line 15
        pulse(16'h8000);
        ack_expect("R10", 15); eoi(15);

        // R11 spurious acknowledge
        do_ack();
        check("R11", vec_o, 8'h27);
        check("R11", {7'd0, vec_vld_o}, 8'd1);
        pulse(16'h0080);
        ack_expect("R11", 7); eoi(7);

        // Random masks and bursts (R3, R4)
        for (int it = 0; it < 40; it++) begin
            logic [15:0] m, p;
            m = 16'($urandom) & 16'hFFFB;
            p = 16'($urandom) & 16'hFFFB;
            io_wr(16'h0021, m[7:0]); io_wr(16'h00A1, m[15:8]);
            pulse(p);
            drain("R3", p & ~m);
            check("R4", {7'd0, int_o}, 8'd0);
            io_wr(16'h0021, 8'h00); io_wr(16'h00A1, 8'h00);
            drain("R4", p & m);
            check("R4", {7'd0, int_o}, 8'd0);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule